// File: doc/BRIEF.md
# Single-Cycle Integer Arithmetic Core

This block is a one-instruction-per-clock processor datapath for the 32-bit base integer arithmetic subset. Each cycle it drives the program counter onto an instruction-memory address port. It takes the 32-bit instruction word back combinationally and decodes it. It reads up to two source registers and computes a result with the ALU. At the next clock edge it writes that result, or an upper immediate, to the destination register. The program counter steps forward by four on every edge. No next-PC source other than that increment exists.

The instruction fetch is a plain combinational read port, not a valid/ready stream. A new word is consumed on every clock, so the memory behind it must answer within the same cycle and cannot apply back-pressure. The core has no stall input. A separate debug read port lets a test or a neighbouring block observe any architectural register without disturbing execution. The ALU zero indication is brought out for observation.

Top module: `rv_arith_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter returns to 0 and every register is cleared, so `imem_addr` reads 0 and every register reads 0 on the debug port.
- R2: After reset is released, `imem_addr` increases by exactly 4 at every rising clock edge, and the word on `imem_data` is the instruction executed in that cycle.
- R3: Register 0 always reads as zero on every read port, and an instruction that names it as destination changes nothing.
- R4: Opcode 0010011 with funct3 (bits 14:12) of 000, 010, 011, 100, 110 or 111 performs add, signed set-less-than, unsigned set-less-than, xor, or, or and of rs1 (bits 19:15) with the sign-extended 12-bit immediate in bits 31:20. The result goes to rd (bits 11:7).
- R5: Opcode 0010011 with funct3 001 shifts left, and with funct3 101 shifts right. The shift amount is bits 24:20. For the right shift, bit 30 selects an arithmetic shift when 1 and a logical shift when 0.
- R6: Opcode 0110011 applies the same funct3 operations to rs1 and rs2 (bits 24:20). With funct3 000, bit 30 selects subtract when 1 and add when 0.
- R7: Register-register shifts use only the low 5 bits of rs2 as the amount. An arithmetic right shift fills the vacated bits with the sign bit.
- R8: Opcode 0110111 writes bits 31:12 of the instruction, followed by twelve zero bits, to rd.
- R9: A register written by an instruction reads its old value during that instruction's cycle. It reads the new value from the next cycle on, so back-to-back dependent instructions see the updated value.
- R10: `alu_zero` is high exactly when the ALU result of the current instruction is 0.
- R11: An instruction whose opcode is none of the three above writes no register.
- R12: Signed set-less-than treats operands as two's complement and unsigned set-less-than treats them as unsigned magnitudes. Each produces 1 or 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction to execute (the PC) |
| imem_data | input | 32 | Instruction word returned combinationally for `imem_addr` |
| alu_zero | output | 1 | High when the current ALU result is zero |
| dbg_addr | input | 5 | Register index for the debug read port |
| dbg_data | output | 32 | Combinational value of the register selected by `dbg_addr` |

## Verification
A corrupted program counter appears on `imem_addr` in the same cycle, because the address port shows the PC register directly. A wrong decode, operand selection or ALU result goes into the destination register at the next edge, so the debug port shows it one cycle after the offending instruction. A bad value in a source register spreads into every later result that reads it. A register write that should have been suppressed, or a late write, shows as an unexpected or stale value on the debug port in the following cycle.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  localparam int XLEN = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_IMM_ALU = 7'b0010011;
  localparam logic [6:0] OPC_REG_ALU = 7'b0110011;
  localparam logic [6:0] OPC_UPPER   = 7'b0110111;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_XOR,
    ALU_OR, ALU_AND, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic { OPB_REG, OPB_IMM } opb_sel_e;
  typedef enum logic [1:0] { IMM_I, IMM_SH, IMM_U } imm_sel_e;
  typedef enum logic { WB_ALU, WB_IMM } wb_sel_e;

  typedef struct packed {
    alu_op_e  op;
    opb_sel_e opb;
    imm_sel_e imm;
    wb_sel_e  wb;
    logic     we;
  } ctrl_t;
endpackage

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
(
  input  logic [31:0]       instr,
  output logic [6:0]        opcode,
  output logic [2:0]        funct3,
  output logic              alt_bit,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd,
  output logic [XLEN-1:0]   imm_i,
  output logic [XLEN-1:0]   imm_sh,
  output logic [XLEN-1:0]   imm_u
);
  // Pure field slicing; every immediate is formed regardless of format.
  assign opcode  = instr[6:0];
  assign rd      = instr[11:7];
  assign funct3  = instr[14:12];
  assign rs1     = instr[19:15];
  assign rs2     = instr[24:20];
  assign alt_bit = instr[30];
  assign imm_i   = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_sh  = {{(XLEN-5){1'b0}}, instr[24:20]};
  assign imm_u   = {instr[31:12], 12'b0};
endmodule

// File: rtl/rvc_control.sv
module rvc_control
  import rvc_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic       alt_bit,
  output ctrl_t      ctrl
);
  function automatic alu_op_e map_f3(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  logic is_shift;
  assign is_shift = (funct3 == 3'b001) || (funct3 == 3'b101);

  always_comb begin
    ctrl.op  = ALU_ADD;
    ctrl.opb = OPB_IMM;
    ctrl.imm = IMM_I;
    ctrl.wb  = WB_ALU;
    ctrl.we  = 1'b0;
    case (opcode)
      OPC_IMM_ALU: begin
        // bit 30 is immediate data except for the right shift
        ctrl.op  = map_f3(funct3, alt_bit && (funct3 == 3'b101));
        ctrl.imm = is_shift ? IMM_SH : IMM_I;
        ctrl.we  = 1'b1;
      end
      OPC_REG_ALU: begin
        ctrl.op  = map_f3(funct3, alt_bit);
        ctrl.opb = OPB_REG;
        ctrl.we  = 1'b1;
      end
      OPC_UPPER: begin
        ctrl.imm = IMM_U;
        ctrl.wb  = WB_IMM;
        ctrl.we  = 1'b1;
      end
      default: ctrl.we = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
  parameter int WIDTH = 32,
  parameter int AW    = 5,
  parameter int NRD   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr [NRD],
  output logic [WIDTH-1:0] rdata [NRD]
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][WIDTH-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) regs <= '0;
    else if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
  import rvc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             zero
);
  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0] sh;
  logic           lt_s, lt_u;
  assign sh   = b[SHW-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    case (op)
      ALU_ADD:  res = a + b;
      ALU_SUB:  res = a - b;
      ALU_SLT:  res = {{(WIDTH-1){1'b0}}, lt_s};
      ALU_SLTU: res = {{(WIDTH-1){1'b0}}, lt_u};
      ALU_XOR:  res = a ^ b;
      ALU_OR:   res = a | b;
      ALU_AND:  res = a & b;
      ALU_SLL:  res = a << sh;
      ALU_SRL:  res = a >> sh;
      ALU_SRA:  res = $unsigned($signed(a) >>> sh);
      default:  res = '0;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/rv_arith_core.sv
module rv_arith_core
  import rvc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [31:0]       imem_addr,
  input  logic [31:0]       imem_data,
  output logic              alu_zero,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [XLEN-1:0]   dbg_data
);
  localparam int NRD = 3;

  logic [31:0] pc_q;
  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_q + 32'(PC_STEP);
  end
  assign imem_addr = pc_q;

  logic [6:0]        opcode;
  logic [2:0]        funct3;
  logic              alt_bit;
  logic [REG_AW-1:0] rs1, rs2, rd_addr;
  logic [XLEN-1:0]   imm_i, imm_sh, imm_u;

  rvc_decode u_dec (
    .instr(imem_data), .opcode(opcode), .funct3(funct3), .alt_bit(alt_bit),
    .rs1(rs1), .rs2(rs2), .rd(rd_addr),
    .imm_i(imm_i), .imm_sh(imm_sh), .imm_u(imm_u)
  );

  ctrl_t ctrl;
  rvc_control u_ctl (
    .opcode(opcode), .funct3(funct3), .alt_bit(alt_bit), .ctrl(ctrl)
  );

  logic [REG_AW-1:0] rf_ra [NRD];
  logic [XLEN-1:0]   rf_rd [NRD];
  logic              rf_we;
  logic [XLEN-1:0]   wb_data;

  assign rf_ra[0] = rs1;
  assign rf_ra[1] = rs2;
  assign rf_ra[2] = dbg_addr;
  assign rf_we    = ctrl.we;

  rvc_regfile #(.WIDTH(XLEN), .AW(REG_AW), .NRD(NRD)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rd_addr), .wdata(wb_data),
    .raddr(rf_ra), .rdata(rf_rd)
  );
  assign dbg_data = rf_rd[2];

  logic [XLEN-1:0] imm_val, opb_val, alu_res;
  always_comb begin
    case (ctrl.imm)
      IMM_SH:  imm_val = imm_sh;
      IMM_U:   imm_val = imm_u;
      default: imm_val = imm_i;
    endcase
  end
  assign opb_val = (ctrl.opb == OPB_IMM) ? imm_val : rf_rd[1];

  rvc_alu #(.WIDTH(XLEN)) u_alu (
    .op(ctrl.op), .a(rf_rd[0]), .b(opb_val), .res(alu_res), .zero(alu_zero)
  );

  assign wb_data = (ctrl.wb == WB_IMM) ? imm_val : alu_res;
endmodule

// File: rtl/rvc_core_checker.sv
module rvc_core_checker
  import rvc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       pc,
  input logic [6:0]        opcode,
  input logic [19:0]       upper_field,
  input logic              rf_we,
  input logic [XLEN-1:0]   wb_data,
  input logic [REG_AW-1:0] dbg_addr,
  input logic [XLEN-1:0]   dbg_data
);
  logic known_op;
  assign known_op = (opcode == OPC_IMM_ALU) || (opcode == OPC_REG_ALU) || (opcode == OPC_UPPER);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == RESET_PC); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(pc) + 32'd4); // R2

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    dbg_addr == '0 |-> dbg_data == '0); // R3

  AST_KNOWN_OP_WRITES: assert property (@(posedge clk) disable iff (rst)
    known_op |-> rf_we); // R4

  AST_UPPER_WB: assert property (@(posedge clk) disable iff (rst)
    opcode == OPC_UPPER |-> wb_data == {upper_field, 12'b0}); // R8

  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> !rf_we); // R11
endmodule

bind rv_arith_core rvc_core_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .pc(imem_addr), .opcode(imem_data[6:0]),
  .upper_field(imem_data[31:12]), .rf_we(rf_we), .wb_data(wb_data),
  .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/rv_arith_core_bench.sv
module rv_arith_core_bench;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam int ROM_WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data;
  logic        alu_zero;
  logic [4:0]  dbg_addr = 5'd0;
  logic [31:0] dbg_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit run_done = 1'b0;

  always #10 clk = ~clk;

  rv_arith_core u_rv_arith_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .alu_zero(alu_zero), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  logic [31:0] rom [ROM_WORDS];
  assign imem_data = (imem_addr[31:2] < 30'(ROM_WORDS)) ? rom[imem_addr[7:2]] : NOP;

  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_u(int imm20, int rd);
    return {imm20[19:0], rd[4:0], 7'b0110111};
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  typedef struct { int req; int r; logic [31:0] v; } exp_t;
  exp_t sb_q [$];

  task automatic push_exp(input int req, input int r, input logic [31:0] v);
    exp_t e;
    e.req = req; e.r = r; e.v = v;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // program
  initial begin
    for (int i = 0; i < ROM_WORDS; i++) rom[i] = NOP;
    rom[0]  = enc_i(12'hbad, 0, 0, 11);        // x11 = sext(0xbad)
    rom[1]  = enc_i(1, 11, 0, 11);             // x11 += 1
    rom[2]  = enc_u(20'h80000, 5);             // x5 upper
    rom[3]  = enc_i(-1, 0, 0, 6);              // x6 = -1
    rom[4]  = enc_i(0, 6, 2, 7);               // slti
    rom[5]  = enc_i(-1, 0, 3, 8);              // sltiu
    rom[6]  = enc_i(12'h0f0, 6, 4, 12);        // xori
    rom[7]  = enc_i(12'h123, 0, 6, 13);        // ori
    rom[8]  = enc_i(12'h7ff, 6, 7, 14);        // andi
    rom[9]  = enc_i(4, 13, 1, 15);             // slli
    rom[10] = enc_i(12'h404, 5, 5, 16);        // srai
    rom[11] = enc_i(4, 5, 5, 17);              // srli
    rom[12] = enc_r(0, 15, 13, 0, 18);         // add
    rom[13] = enc_r(7'h20, 13, 13, 0, 19);     // sub -> 0
    rom[14] = enc_i(35, 0, 0, 20);             // x20 = 35
    rom[15] = enc_r(0, 20, 13, 1, 21);         // sll
    rom[16] = enc_r(7'h20, 20, 5, 5, 22);      // sra
    rom[17] = enc_r(0, 20, 5, 5, 23);          // srl
    rom[18] = enc_r(0, 13, 6, 4, 24);          // xor
    rom[19] = enc_r(0, 15, 13, 6, 25);         // or
    rom[20] = enc_r(0, 15, 6, 7, 26);          // and
    rom[21] = enc_i(5, 0, 0, 0);               // write to x0
    rom[22] = {12'h005, 5'd0, 3'd0, 5'd27, 7'h7f}; // unknown opcode
    rom[23] = enc_r(0, 0, 5, 2, 9);            // slt
    rom[24] = enc_r(0, 5, 0, 3, 10);           // sltu
    rom[26] = enc_r(7'h20, 13, 0, 0, 29);      // sub -> nonzero
  end

  // driver: stimulus, fetch-side checks and expected register contents
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    dbg_addr = 5'd11;
    #1;
    check(1, imem_addr, 32'h0);   // R1 PC at reset value
    check(1, dbg_data, 32'h0);    // R1 registers cleared
    rst = 1'b0;
    #1;
    check(9, dbg_data, 32'h0);    // R9 write of instruction 0 not yet visible
    for (int k = 0; k < 30; k++) begin
      check(2, imem_addr, 32'(4 * k)); // R2
      if (k == 1) check(9, dbg_data, 32'hFFFF_FBAD);      // R9 visible next cycle
      if (k == 0) check(10, {31'b0, alu_zero}, 32'd0);   // R10
      if (k == 13) check(10, {31'b0, alu_zero}, 32'd1);  // R10 sub equal operands
      if (k == 26) check(10, {31'b0, alu_zero}, 32'd0);  // R10
      @(posedge clk);
      @(negedge clk);
      #1;
    end
    push_exp(9, 11, 32'hFFFF_FBAE);  // R9 dependent chain
    push_exp(8, 5, 32'h8000_0000);   // R8
    push_exp(4, 6, 32'hFFFF_FFFF);   // R4
    push_exp(12, 7, 32'd1);          // R12 slti
    push_exp(12, 8, 32'd1);          // R12 sltiu
    push_exp(12, 9, 32'd1);          // R12 slt
    push_exp(12, 10, 32'd1);         // R12 sltu
    push_exp(4, 12, 32'hFFFF_FF0F);  // R4 xori
    push_exp(4, 13, 32'h0000_0123);  // R4 ori
    push_exp(4, 14, 32'h0000_07FF);  // R4 andi
    push_exp(5, 15, 32'h0000_1230);  // R5 slli
    push_exp(5, 16, 32'hF800_0000);  // R5 srai
    push_exp(5, 17, 32'h0800_0000);  // R5 srli
    push_exp(6, 18, 32'h0000_1353);  // R6 add
    push_exp(6, 19, 32'h0);          // R6 sub
    push_exp(7, 21, 32'h0000_0918);  // R7 sll by 35 -> 3
    push_exp(7, 22, 32'hF000_0000);  // R7 sra sign fill
    push_exp(7, 23, 32'h1000_0000);  // R7 srl
    push_exp(6, 24, 32'hFFFF_FEDC);  // R6 xor
    push_exp(6, 25, 32'h0000_1333);  // R6 or
    push_exp(6, 26, 32'h0000_1230);  // R6 and
    push_exp(3, 0, 32'h0);           // R3
    push_exp(11, 27, 32'h0);         // R11
    push_exp(6, 29, 32'hFFFF_FEDD);  // R6 negative difference
    run_done = 1'b1;
  end

  // monitor: pops expected items and compares at the debug port
  initial begin
    wait (run_done);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      @(negedge clk);
      dbg_addr = 5'(e.r);
      #2;
      check(e.req, dbg_data, e.v);
    end
    finish_run();
  end

  initial begin
    #(20 * 5000);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=%08h expected=%08h", imem_addr, 32'h0);
    finish_run();
  end
endmodule